// File: doc/BRIEF.md
# Sized Shifter with Carry

A single-cycle shift unit for an execution pipeline. One operand is shifted at one of three sizes: a quarter, half or full data word (8, 16 or 32 bits by default). Five operations are available: logical left, logical right, arithmetic right, and left or right with the incoming carry. The shift count comes from a wider operand and is cut down to the number of bits the selected size needs.

The sized result is written into the low part of the old destination value, and the bits above the operation size keep their old contents. The unit also returns new values for four flags (carry, overflow, sign, zero) together with a per-flag write mask. A mode input chooses between two flag policies. The legacy policy updates only carry. The full policy updates all four flags.

Results, flags and mask are registered. They appear one clock after a request is accepted with `in_valid`.

Top module: `sized_shifter`

## Requirements
- R1: Only the low bits of `shamt` are used as the count: 3 bits for size code 0 (8-bit), 4 bits for size code 1 (16-bit), 5 bits for size codes 2 and 3 (32-bit). Higher count bits have no effect on any output.
- R2: Operation codes 0 (shift left) and 1 (shift right) fill every vacated bit with 0. Codes 5 to 7 behave as code 0.
- R3: Operation code 2 (arithmetic right) fills the vacated upper bits with the source sign bit, taken at the operation size.
- R4: Code 3 (left with carry) places `carry_in` at bit count-1. Code 4 (right with carry) places it at bit size-count. Every other vacated bit is 0.
- R5: `flag_c` is the last bit shifted out. For left shifts this is source bit size-count. For right shifts it is source bit count-1. It is 0 when the masked count is 0.
- R6: A masked count of 0 returns the sized source unchanged for all five operations, and no carry is inserted.
- R7: With `full_mode`=1, `flag_wr_mask` is 4'b1111. `flag_o` is 0, `flag_s` is the top bit of the sized result, and `flag_z` is 1 exactly when the sized result is 0.
- R8: With `full_mode`=0, `flag_wr_mask` is 4'b0001 (carry only), and `flag_o`, `flag_s` and `flag_z` are driven 0. The mask bit order is [0]=carry, [1]=overflow, [2]=sign, [3]=zero.
- R9: For 8-bit and 16-bit sizes, `dst_new` bits above the size equal the corresponding bits of `dst_old`.
- R10: Outputs are registered. `out_valid` follows `in_valid` by one clock. Synchronous reset clears `out_valid`, `dst_new`, the flags and the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_val | input | DATA_W | Value to shift |
| dst_old | input | DATA_W | Old destination contents |
| shamt | input | CNT_W | Shift-count operand before masking |
| size_sel | input | 2 | 0: 8-bit, 1: 16-bit, 2/3: 32-bit |
| op_sel | input | 3 | 0 shl, 1 shr, 2 sar, 3 shl with carry, 4 shr with carry |
| carry_in | input | 1 | Current carry flag |
| full_mode | input | 1 | 1: full flag policy, 0: legacy policy |
| out_valid | output | 1 | Result valid |
| dst_new | output | DATA_W | Merged destination value |
| flag_c | output | 1 | New carry |
| flag_o | output | 1 | New overflow |
| flag_s | output | 1 | New sign |
| flag_z | output | 1 | New zero |
| flag_wr_mask | output | 4 | Flag write enables, [0] carry to [3] zero |

## Verification
The hard cases are those where carry insertion and the zero-count rule, or carry insertion and carry out, meet in one operation. A carry variant with count 1 inserts at the very edge bit while shifting out the opposite edge bit. A masked count of 0 must suppress both insertion and carry out. The bench sweeps every masked count at each size with `carry_in` at 0 and 1, and with raw counts whose upper bits are set. Every registered output is compared against a bit-by-bit behavioural model on each clock.

// File: rtl/shf_pkg.sv
package shf_pkg;

  // operation select codes
  localparam logic [2:0] OP_SHL  = 3'd0;
  localparam logic [2:0] OP_SHR  = 3'd1;
  localparam logic [2:0] OP_SAR  = 3'd2;
  localparam logic [2:0] OP_SHLC = 3'd3;
  localparam logic [2:0] OP_SHRC = 3'd4;

  // size select codes (3 is treated as full word)
  localparam logic [1:0] SZ_QUARTER = 2'd0;
  localparam logic [1:0] SZ_HALF    = 2'd1;
  localparam logic [1:0] SZ_WORD    = 2'd2;

  // flag bundle, bit 0 carry up to bit 3 zero
  typedef struct packed {
    logic z;
    logic s;
    logic o;
    logic c;
  } shf_flags_t;

  localparam logic [3:0] MASK_FULL   = 4'b1111;
  localparam logic [3:0] MASK_LEGACY = 4'b0001;

endpackage

// File: rtl/shf_count_mask.sv
module shf_count_mask #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int CNT_MW = $clog2(DATA_W)
) (
  input  logic [CNT_W-1:0]  cnt_raw,
  input  logic [1:0]        size_sel,
  output logic [CNT_MW-1:0] cnt_m,
  output logic              cnt_zero
);
  import shf_pkg::*;

  logic [CNT_MW-1:0] keep;

  // count width shrinks by one bit per halving of the operand size
  always_comb begin
    unique case (size_sel)
      SZ_QUARTER: keep = {CNT_MW{1'b1}} >> 2;
      SZ_HALF:    keep = {CNT_MW{1'b1}} >> 1;
      default:    keep = {CNT_MW{1'b1}};
    endcase
    cnt_m    = cnt_raw[CNT_MW-1:0] & keep;
    cnt_zero = (cnt_m == '0);
  end

endmodule

// File: rtl/shf_lane.sv
module shf_lane #(
  parameter int W  = 8,
  parameter int LW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic [LW-1:0] n,
  input  logic          dir_left,
  input  logic          fill_sign,
  input  logic          ins_carry,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);

  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic          nz;
  logic [LW-1:0] nm1;
  logic [LW-1:0] lidx;
  logic [W-1:0]  left_res;
  logic [W-1:0]  right_res;
  logic [W-1:0]  sign_fill;
  logic [W-1:0]  l_ins;
  logic [W-1:0]  r_ins;

  always_comb begin
    nz   = (n != '0);
    nm1  = n - LW'(1);
    // W is a power of two, so W - n wraps correctly into LW bits
    lidx = LW'(W) - n;

    l_ins     = (ins_carry && nz) ? (W'(cin) << nm1) : '0;
    r_ins     = (ins_carry && nz) ? ({cin, {(W-1){1'b0}}} >> nm1) : '0;
    sign_fill = (fill_sign && src[W-1]) ? ~(ONES >> n) : '0;

    left_res  = (src << n) | l_ins;
    right_res = (src >> n) | sign_fill | r_ins;

    res  = dir_left ? left_res : right_res;
    cout = nz & (dir_left ? src[lidx] : src[nm1]);
  end

endmodule

// File: rtl/shf_flag_merge.sv
module shf_flag_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   res_ext,
  input  logic [1:0]          size_sel,
  input  logic [DATA_W-1:0]   dst_old,
  input  logic                cout,
  input  logic                full_mode,
  output logic [DATA_W-1:0]   dst_next,
  output shf_pkg::shf_flags_t flg,
  output logic [3:0]          mask
);
  import shf_pkg::*;

  localparam int WQ = DATA_W / 4;
  localparam int WH = DATA_W / 2;

  logic top_bit;

  always_comb begin
    unique case (size_sel)
      SZ_QUARTER: begin
        dst_next = {dst_old[DATA_W-1:WQ], res_ext[WQ-1:0]};
        top_bit  = res_ext[WQ-1];
      end
      SZ_HALF: begin
        dst_next = {dst_old[DATA_W-1:WH], res_ext[WH-1:0]};
        top_bit  = res_ext[WH-1];
      end
      default: begin
        dst_next = res_ext;
        top_bit  = res_ext[DATA_W-1];
      end
    endcase
    // res_ext is zero above the size, so a full compare is a sized compare
    flg.c = cout;
    flg.o = 1'b0;
    flg.s = full_mode & top_bit;
    flg.z = full_mode & (res_ext == '0);
    mask  = full_mode ? MASK_FULL : MASK_LEGACY;
  end

endmodule

// File: rtl/sized_shifter.sv
module sized_shifter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [CNT_W-1:0]  shamt,
  input  logic [1:0]        size_sel,
  input  logic [2:0]        op_sel,
  input  logic              carry_in,
  input  logic              full_mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] dst_new,
  output logic              flag_c,
  output logic              flag_o,
  output logic              flag_s,
  output logic              flag_z,
  output logic [3:0]        flag_wr_mask
);
  import shf_pkg::*;

  localparam int CNT_MW  = $clog2(DATA_W);
  localparam int N_LANES = 3;
  localparam int WQ      = DATA_W / 4;
  localparam int WH      = DATA_W / 2;

  // ---------------- count masking ----------------
  logic [CNT_MW-1:0] cnt_m;
  logic              cnt_zero;

  shf_count_mask #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .CNT_MW (CNT_MW)
  ) u_cnt (
    .cnt_raw  (shamt),
    .size_sel (size_sel),
    .cnt_m    (cnt_m),
    .cnt_zero (cnt_zero)
  );

  // ---------------- operation decode ----------------
  logic dir_left, fill_sign, ins_carry;

  always_comb begin
    fill_sign = (op_sel == OP_SAR);
    ins_carry = (op_sel == OP_SHLC) || (op_sel == OP_SHRC);
    dir_left  = !((op_sel == OP_SHR) || (op_sel == OP_SAR) || (op_sel == OP_SHRC));
  end

  // ---------------- one lane per size ----------------
  logic [DATA_W-1:0] lane_res  [N_LANES];
  logic              lane_cout [N_LANES];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW_G = CNT_MW - 2 + g;
    localparam int W_G  = 1 << LW_G;
    logic [W_G-1:0] res_l;
    logic           cout_l;

    shf_lane #(
      .W  (W_G),
      .LW (LW_G)
    ) u_lane (
      .src       (src_val[W_G-1:0]),
      .n         (cnt_m[LW_G-1:0]),
      .dir_left  (dir_left),
      .fill_sign (fill_sign),
      .ins_carry (ins_carry),
      .cin       (carry_in),
      .res       (res_l),
      .cout      (cout_l)
    );

    assign lane_res[g]  = DATA_W'(res_l);
    assign lane_cout[g] = cout_l;
  end

  logic [DATA_W-1:0] res_sel;
  logic              cout_sel;

  always_comb begin
    unique case (size_sel)
      SZ_QUARTER: begin res_sel = lane_res[0]; cout_sel = lane_cout[0]; end
      SZ_HALF:    begin res_sel = lane_res[1]; cout_sel = lane_cout[1]; end
      default:    begin res_sel = lane_res[2]; cout_sel = lane_cout[2]; end
    endcase
  end

  // ---------------- merge and flags ----------------
  logic [DATA_W-1:0] dst_next;
  shf_flags_t        flg_next;
  logic [3:0]        mask_next;

  shf_flag_merge #(
    .DATA_W (DATA_W)
  ) u_merge (
    .res_ext   (res_sel),
    .size_sel  (size_sel),
    .dst_old   (dst_old),
    .cout      (cout_sel),
    .full_mode (full_mode),
    .dst_next  (dst_next),
    .flg       (flg_next),
    .mask      (mask_next)
  );

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      dst_new      <= '0;
      flag_c       <= 1'b0;
      flag_o       <= 1'b0;
      flag_s       <= 1'b0;
      flag_z       <= 1'b0;
      flag_wr_mask <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_new      <= dst_next;
        flag_c       <= flg_next.c;
        flag_o       <= flg_next.o;
        flag_s       <= flg_next.s;
        flag_z       <= flg_next.z;
        flag_wr_mask <= mask_next;
      end
    end
  end

  // ---------------- assertions ----------------
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r10_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r8_mask_policy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_wr_mask == ($past(full_mode) ? MASK_FULL : MASK_LEGACY)));

  a_r8_legacy_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(full_mode)) |-> (!flag_s && !flag_z));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !flag_o);

  a_r7_sign_word: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(full_mode) && $past(size_sel[1])) |-> (flag_s == dst_new[DATA_W-1]));

  a_r5_zero_count_no_carry: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(cnt_zero)) |-> !flag_c);

  a_r6_zero_count_pass: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(cnt_zero) && $past(size_sel[1])) |-> (dst_new == $past(src_val)));

  a_r9_upper_quarter: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(size_sel) == SZ_QUARTER) |->
      (dst_new[DATA_W-1:WQ] == $past(dst_old[DATA_W-1:WQ])));

  a_r9_upper_half: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(size_sel) == SZ_HALF) |->
      (dst_new[DATA_W-1:WH] == $past(dst_old[DATA_W-1:WH])));

endmodule

// File: tb/sized_shifter_test.sv
`timescale 1ns/1ps
module sized_shifter_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] src_val, dst_old;
  logic [7:0]  shamt;
  logic [1:0]  size_sel;
  logic [2:0]  op_sel;
  logic        carry_in, full_mode;
  logic        out_valid;
  logic [31:0] dst_new;
  logic        flag_c, flag_o, flag_s, flag_z;
  logic [3:0]  flag_wr_mask;

  always #2.5 clk = ~clk;

  sized_shifter #(.DATA_W(32), .CNT_W(8)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_val(src_val),
    .dst_old(dst_old), .shamt(shamt), .size_sel(size_sel), .op_sel(op_sel),
    .carry_in(carry_in), .full_mode(full_mode), .out_valid(out_valid),
    .dst_new(dst_new), .flag_c(flag_c), .flag_o(flag_o), .flag_s(flag_s),
    .flag_z(flag_z), .flag_wr_mask(flag_wr_mask)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // pending expectation for the request driven one cycle earlier
  bit          pend = 0;
  bit          exp_idle = 0;
  logic [31:0] e_dst;
  bit          e_c, e_s, e_z, e_fm;
  int          e_w;
  string       e_tag;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural model, one bit at a time
  function automatic void model(input logic [31:0] s, input int n, input int w,
                                input int op, input bit ci,
                                output logic [31:0] r, output bit c);
    bit left;
    left = !(op == 1 || op == 2 || op == 4);
    r = '0;
    for (int i = 0; i < w; i++) begin
      bit b;
      if (left) begin
        if (i >= n) b = s[i-n];
        else        b = (op == 3 && i == n - 1) ? ci : 1'b0;
      end else begin
        if (i + n < w)    b = s[i+n];
        else if (op == 2) b = s[w-1];
        else              b = (op == 4 && i == w - n) ? ci : 1'b0;
      end
      r[i] = b;
    end
    if (n == 0)    c = 1'b0;
    else if (left) c = s[w-n];
    else           c = s[n-1];
  endfunction

  task automatic compare_pending();
    if (pend) begin
      logic [31:0] lowm;
      lowm = (e_w == 32) ? 32'hFFFF_FFFF : ((32'd1 << e_w) - 1);
      chk({31'd0, out_valid}, 32'd1, "R10 valid");
      chk(dst_new & lowm, e_dst & lowm, e_tag);
      if (e_w < 32) chk(dst_new & ~lowm, e_dst & ~lowm, "R9 upper bits");
      chk({31'd0, flag_c}, {31'd0, e_c}, "R5 carry out");
      if (e_fm) begin
        chk({29'd0, flag_z, flag_s, flag_o}, {29'd0, e_z, e_s, 1'b0}, "R7 z/s/o");
        chk({28'd0, flag_wr_mask}, 32'hF, "R7 mask");
      end else begin
        chk({29'd0, flag_z, flag_s, flag_o}, 32'd0, "R8 z/s/o quiet");
        chk({28'd0, flag_wr_mask}, 32'h1, "R8 mask");
      end
    end else if (exp_idle) begin
      chk({31'd0, out_valid}, 32'd0, "R10 idle");
    end
  endtask

  task automatic send(input logic [31:0] s, input logic [7:0] raw, input int sz,
                      input int op, input bit ci, input bit fm, input logic [31:0] d);
    int w, n;
    logic [31:0] r;
    bit c;
    @(negedge clk);
    compare_pending();
    w = 8 << sz;
    n = int'(raw) % w;
    in_valid = 1'b1; src_val = s; shamt = raw; size_sel = sz[1:0];
    op_sel = op[2:0]; carry_in = ci; full_mode = fm; dst_old = d;
    model(s, n, w, op, ci, r, c);
    if (w == 32) e_dst = r;
    else e_dst = (d & ~((32'd1 << w) - 1)) | r;
    e_c  = c;
    e_z  = (r == 0);
    e_s  = r[w-1];
    e_fm = fm;
    e_w  = w;
    if (n == 0)           e_tag = "R6 zero count";
    else if (raw != n)    e_tag = "R1 count mask";
    else if (op == 2)     e_tag = "R3 sign fill";
    else if (op >= 3)     e_tag = "R4 carry insert";
    else                  e_tag = "R2 zero fill";
    pend = 1; exp_idle = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    compare_pending();
    in_valid = 1'b0;
    pend = 0; exp_idle = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; src_val = '0; dst_old = '0; shamt = '0;
    size_sel = '0; op_sel = '0; carry_in = 1'b0; full_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk({31'd0, out_valid}, 32'd0, "R10 reset valid");
    chk(dst_new, 32'd0, "R10 reset dst");
    chk({28'd0, flag_wr_mask}, 32'd0, "R10 reset mask");
    rst = 1'b0;

    // full sweep: every size, every masked count, every op, both carry values
    for (int sz = 0; sz < 3; sz++) begin
      for (int n = 0; n < (8 << sz); n++) begin
        for (int op = 0; op < 5; op++) begin
          for (int ci = 0; ci < 2; ci++) begin
            logic [31:0] s, d;
            logic [7:0]  raw;
            s   = (ci != 0) ? 32'hF0E1_D2C3 : 32'h0F1E_2D3C;
            s   = s ^ (32'h0101_0101 * op) ^ (32'(n) << 3);
            d   = 32'h1357_9BDF ^ (32'(n) << 16) ^ 32'(op);
            raw = 8'((8 << sz) * ((op + ci) % 4) + n);
            send(s, raw, sz, op, ci[0], ((n + ci) % 2) == 0, d);
          end
        end
        if ((n % 7) == 3) idle();
      end
    end

    // directed corners
    send(32'h0000_0000, 8'd5,  2, 0, 1'b0, 1'b1, 32'hDEAD_BEEF);  // zero result
    send(32'h0000_0080, 8'd7,  0, 2, 1'b0, 1'b1, 32'hAAAA_AAAA);  // byte sign fill
    send(32'h0000_8000, 8'd1,  1, 4, 1'b1, 1'b1, 32'h5555_5555);  // half carry at top
    send(32'h8000_0001, 8'd1,  2, 3, 1'b1, 1'b1, 32'h0);          // carry in and out
    send(32'hFFFF_FFFF, 8'd32, 2, 4, 1'b1, 1'b0, 32'h0);          // masked to zero
    send(32'h0000_00FF, 8'd5,  0, 7, 1'b1, 1'b1, 32'h1234_5678);  // spare code as shl
    idle();
    idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule